// File: doc/BRIEF.md
# Programmable Timebase Tick Generator

This block turns one low-rate reference enable into four streams of one-clock tick pulses. A 15-bit binary counter advances once per reference enable. The reference is nominally 32768 Hz, given as a single-cycle strobe in the system clock domain. Every output rate is taken from one bit of that shared counter. An output fires on the cycle after the chosen bit goes from 0 to 1.

Two timebase outputs each have their own 2-bit rate select. One covers 128 to 1024 Hz and the other covers 8 to 64 Hz. A fast interrupt ticker offers 1024, 2048 or 4096 Hz. A slow interrupt ticker runs at a fixed 4 Hz. All three selects sit in one small configuration word, written through a single-cycle write strobe. A synchronous reset clears the counter and every select.

Top module: `tbgen_top`

## Requirements
- R1: The fast timebase (`tb_fast_tick`) uses counter bit 7 minus its select, which is field bits [1:0] of the configuration word. So 00 gives 128 Hz, 01 gives 256 Hz, 10 gives 512 Hz and 11 gives 1024 Hz. Its tick follows the n-th reference enable since reset exactly when n mod 2^(b+1) equals 2^b, where b is the selected bit.
- R2: The slow timebase (`tb_slow_tick`) uses counter bit 11 minus its select, which is field bits [3:2]. So 00 gives 8 Hz, 01 gives 16 Hz, 10 gives 32 Hz and 11 gives 64 Hz. It follows the same n mod 2^(b+1) = 2^b rule.
- R3: The fast interrupt ticker (`irq_fast_tick`) uses counter bit 4 minus its select, which is field bits [5:4]. So 00 gives 1024 Hz, 01 gives 2048 Hz and 10 gives 4096 Hz. The reserved code 11 behaves like 10, at 4096 Hz (bit 2).
- R4: The slow interrupt ticker (`irq_slow_tick`) uses fixed counter bit 12, which is 4 Hz. It first fires after 4096 reference enables and then every 8192.
- R5: Each tick is exactly one clock wide. It appears in the clock cycle right after the edge that sampled the reference enable causing the bit transition.
- R6: With `ref_tick` low, the counter holds and no output ticks.
- R7: A new select value written through `cfg_we`/`cfg_wdata` applies from the next cycle. The output then fires at the next rising transition of the newly selected bit. The counter is not disturbed, and no pulse is emitted because of the write itself. The configuration holds its value while `cfg_we` is low.
- R8: Synchronous reset clears the counter, all selects (to 00) and all tick outputs.
- R9: The select fields are independent. Rewriting one field leaves the timing of the other outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | Reference enable, one cycle per reference period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Select fields: [1:0] fast timebase, [3:2] slow timebase, [5:4] fast interrupt |
| tb_fast_tick | output | 1 | Fast timebase tick |
| tb_slow_tick | output | 1 | Slow timebase tick |
| irq_fast_tick | output | 1 | Selectable interrupt ticker pulse |
| irq_slow_tick | output | 1 | Fixed 4 Hz interrupt ticker pulse |

## Verification
A tick is due exactly one register stage after the edge that samples the causing reference enable. Each bench step drives its inputs, waits for one rising edge and samples 1 ns later. A step that issues the n-th reference enable must therefore show that enable's tick, and idle steps must show none. A configuration write is seen on the edge that registers it and steers the very next reference enable. The bench expects the new rate's formula from the step after the write, counting n from the last reset.

// File: rtl/tbgen_pkg.sv
package tbgen_pkg;

    localparam int NUM_OUT = 4;
    localparam int SEL_W   = 2;

    // Configuration word, LSB first: fast timebase, slow timebase, fast irq
    typedef struct packed {
        logic [SEL_W-1:0] irq_fast_sel;
        logic [SEL_W-1:0] tb_slow_sel;
        logic [SEL_W-1:0] tb_fast_sel;
    } tbgen_cfg_t;

    localparam int CFG_W = $bits(tbgen_cfg_t);

endpackage

// File: rtl/tbgen_divider.sv
module tbgen_divider #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ref_tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_tick |=> $stable(st_q.cnt));

    // R8
    cnt_clear_chk: assert property (@(posedge clk)
        rst |=> (st_q.cnt == '0));

endmodule

// File: rtl/tbgen_cfg.sv
module tbgen_cfg
    import tbgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output tbgen_cfg_t       cfg
);

    typedef struct packed {
        tbgen_cfg_t cfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.cfg = tbgen_cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(st_q.cfg));

endmodule

// File: rtl/tbgen_tap_pulse.sv
module tbgen_tap_pulse #(
    parameter int CNT_W    = 15,
    parameter int BASE_TAP = 7,
    parameter int MIN_TAP  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       sel,
    output logic             pulse
);

    localparam int TAP_W = $clog2(CNT_W);

    typedef struct packed {
        logic pulse;
    } tap_state_t;

    tap_state_t       st_d, st_q;
    int               tap_i;
    logic [TAP_W-1:0] tap;
    logic [CNT_W-1:0] low_mask;

    always_comb begin
        // Higher select code picks a lower bit (faster rate), floored at MIN_TAP
        tap_i = BASE_TAP - int'(sel);
        if (tap_i < MIN_TAP) begin
            tap_i = MIN_TAP;
        end
        tap      = TAP_W'(tap_i);
        low_mask = (CNT_W'(1) << tap) - CNT_W'(1);
        // Rising transition of the tap on the coming increment
        st_d.pulse = ref_tick && !cnt[tap] && ((cnt & low_mask) == low_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;

    // R5
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |-> $past(ref_tick));

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |=> !st_q.pulse);

endmodule

// File: rtl/tbgen_top.sv
module tbgen_top
    import tbgen_pkg::*;
#(
    parameter int CNT_W         = 15,
    parameter int TB_FAST_TAP   = 7,
    parameter int TB_SLOW_TAP   = 11,
    parameter int IRQ_FAST_TAP  = 4,
    parameter int IRQ_FAST_MIN  = 2,
    parameter int IRQ_SLOW_TAP  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             tb_fast_tick,
    output logic             tb_slow_tick,
    output logic             irq_fast_tick,
    output logic             irq_slow_tick
);

    localparam int TAP_BASE [NUM_OUT] = '{TB_FAST_TAP, TB_SLOW_TAP, IRQ_FAST_TAP, IRQ_SLOW_TAP};
    localparam int TAP_MIN  [NUM_OUT] = '{TB_FAST_TAP - 3, TB_SLOW_TAP - 3, IRQ_FAST_MIN, IRQ_SLOW_TAP};

    logic [CNT_W-1:0]                cnt;
    tbgen_cfg_t                      cfg;
    logic [NUM_OUT-1:0][SEL_W-1:0]   sel_vec;
    logic [NUM_OUT-1:0]              tick_vec;

    tbgen_divider #(.CNT_W(CNT_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .cnt      (cnt)
    );

    tbgen_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    always_comb begin
        sel_vec[0] = cfg.tb_fast_sel;
        sel_vec[1] = cfg.tb_slow_sel;
        sel_vec[2] = cfg.irq_fast_sel;
        sel_vec[3] = '0;
    end

    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_tap
        tbgen_tap_pulse #(
            .CNT_W    (CNT_W),
            .BASE_TAP (TAP_BASE[gi]),
            .MIN_TAP  (TAP_MIN[gi])
        ) u_tap (
            .clk      (clk),
            .rst      (rst),
            .ref_tick (ref_tick),
            .cnt      (cnt),
            .sel      (sel_vec[gi]),
            .pulse    (tick_vec[gi])
        );
    end

    assign tb_fast_tick  = tick_vec[0];
    assign tb_slow_tick  = tick_vec[1];
    assign irq_fast_tick = tick_vec[2];
    assign irq_slow_tick = tick_vec[3];

    // R4
    slow_irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        irq_slow_tick |=> !irq_slow_tick && !tb_slow_tick);

    // R8
    ticks_cleared_chk: assert property (@(posedge clk)
        rst |=> (tick_vec == '0));

endmodule

// File: tb/sim_tbgen_top.sv
module sim_tbgen_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic       tb_fast_tick, tb_slow_tick, irq_fast_tick, irq_slow_tick;

    int checks = 0;
    int fails  = 0;
    int nref   = 0;

    always #2 clk = ~clk;

    tbgen_top u0 (
        .clk           (clk),
        .rst           (rst),
        .ref_tick      (ref_tick),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .tb_fast_tick  (tb_fast_tick),
        .tb_slow_tick  (tb_slow_tick),
        .irq_fast_tick (irq_fast_tick),
        .irq_slow_tick (irq_slow_tick)
    );

    function automatic logic out_of(int idx);
        case (idx)
            0:       return tb_fast_tick;
            1:       return tb_slow_tick;
            2:       return irq_fast_tick;
            default: return irq_slow_tick;
        endcase
    endfunction

    function automatic logic expect_tick(int n, int b);
        return (n % (1 << (b + 1))) == (1 << b);
    endfunction

    task automatic step(logic rt, logic we, logic [5:0] wd);
        ref_tick  = rt;
        cfg_we    = we;
        cfg_wdata = wd;
        @(posedge clk);
        #1;
        ref_tick = 1'b0;
        cfg_we   = 1'b0;
        if (rt && !rst) nref++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        rst  = 1'b0;
        nref = 0;
    endtask

    task automatic check_bits(string req, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: ticks got %b expected %b", req, got, exp);
        end
    endtask

    // Issue 'count' reference enables with 'gap' idle cycles after each,
    // comparing output 'idx' against the bit-b rule every cycle.
    task automatic run_rate(string req, int idx, int b, int count, int gap);
        int bad = 0;
        int first_n = -1;
        logic g_got = 1'b0;
        logic g_exp = 1'b0;
        for (int i = 0; i < count; i++) begin
            step(1'b1, 1'b0, '0);
            if (out_of(idx) !== expect_tick(nref, b)) begin
                if (bad == 0) begin first_n = nref; g_got = out_of(idx); g_exp = expect_tick(nref, b); end
                bad++;
            end
            for (int g = 0; g < gap; g++) begin
                step(1'b0, 1'b0, '0);
                if (out_of(idx) !== 1'b0) begin
                    if (bad == 0) begin first_n = nref; g_got = out_of(idx); g_exp = 1'b0; end
                    bad++;
                end
            end
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: output %0d bit %0d, first miss at ref %0d got %b expected %b (%0d misses)",
                     req, idx, b, first_n, g_got, g_exp, bad);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check_bits("R8 reset outputs", {tb_fast_tick, tb_slow_tick, irq_fast_tick, irq_slow_tick}, 4'b0000);
    endtask

    task automatic t_tb_fast();
        for (int s = 0; s < 4; s++) begin
            do_reset();
            step(1'b0, 1'b1, 6'(s));
            run_rate("R1 fast timebase", 0, 7 - s, (1 << (8 - s)) + (1 << (7 - s)) + 3, 0);
        end
    endtask

    task automatic t_tb_slow();
        for (int s = 0; s < 4; s++) begin
            do_reset();
            step(1'b0, 1'b1, 6'(s << 2));
            run_rate("R2 slow timebase", 1, 11 - s, (1 << (12 - s)) + (1 << (11 - s)) + 3, 0);
        end
    endtask

    task automatic t_irq_fast();
        for (int s = 0; s < 4; s++) begin
            int b = (s == 3) ? 2 : 4 - s;
            do_reset();
            step(1'b0, 1'b1, 6'(s << 4));
            run_rate("R3 fast irq ticker", 2, b, (1 << (b + 1)) * 3, 0);
        end
    endtask

    task automatic t_irq_slow();
        do_reset();
        run_rate("R4 slow irq ticker", 3, 12, 8192 + 4096 + 3, 0);
    endtask

    task automatic t_gapped();
        do_reset();
        step(1'b0, 1'b1, 6'b10_00_11);
        // R5: with idle cycles between enables each pulse is one cycle wide
        run_rate("R5 pulse width", 0, 4, 80, 2);
        run_rate("R5 irq pulse width", 2, 2, 20, 1);
    endtask

    task automatic t_idle();
        int seen = 0;
        do_reset();
        step(1'b0, 1'b1, 6'b10_11_11);
        run_rate("R6 prelude", 0, 4, 15, 0);
        // Counter sits one enable short of bit 4 rising: no tick without ref_tick
        for (int i = 0; i < 50; i++) begin
            step(1'b0, 1'b0, '0);
            if ({tb_fast_tick, tb_slow_tick, irq_fast_tick, irq_slow_tick} != 4'b0) seen++;
        end
        checks++;
        if (seen != 0) begin
            fails++;
            $display("FAIL R6: %0d ticks while idle, expected 0", seen);
        end
        // Next enable must be the 16th: bit 4 rises now if the counter held
        run_rate("R6 counter held", 0, 4, 1, 0);
    endtask

    task automatic t_sel_change();
        do_reset();
        run_rate("R7 before change", 0, 7, 100, 0);
        step(1'b0, 1'b1, 6'b00_00_11);
        check_bits("R7 no pulse on write", {tb_fast_tick, tb_slow_tick, irq_fast_tick, irq_slow_tick}, 4'b0000);
        // Next bit-4 rise at 112, then 144
        run_rate("R7 faster select", 0, 4, 60, 0);
        step(1'b0, 1'b1, 6'b00_00_00);
        // Counter at 160: next bit-7 rise at 384
        run_rate("R7 slower select", 0, 7, 260, 0);
    endtask

    task automatic t_independent();
        do_reset();
        step(1'b0, 1'b1, 6'b00_00_11);
        run_rate("R9 start", 0, 4, 50, 0);
        step(1'b0, 1'b1, 6'b10_11_11);
        run_rate("R9 fast timebase kept", 0, 4, 200, 0);
        do_reset();
        step(1'b0, 1'b1, 6'b00_11_00);
        run_rate("R9 slow base", 1, 8, 300, 0);
        step(1'b0, 1'b1, 6'b11_11_11);
        run_rate("R9 slow timebase kept", 1, 8, 600, 0);
    endtask

    task automatic t_reset_midrun();
        do_reset();
        step(1'b0, 1'b1, 6'b11_11_11);
        run_rate("R8 prelude", 0, 4, 70, 0);
        do_reset();
        // Selects back at 00 and counter at 0: first bit-7 tick at 128
        run_rate("R8 selects and counter cleared", 0, 7, 300, 0);
        run_rate("R8 slow timebase default", 1, 11, 1, 0);
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_tb_fast();
        t_tb_slow();
        t_irq_fast();
        t_irq_slow();
        t_gapped();
        t_idle();
        t_sel_change();
        t_independent();
        t_reset_midrun();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule